// File: doc/BRIEF.md
# Write-Back Write-Allocate Cache Controller

This block is a set-associative cache controller that sits between an upper-level requester and a lower-level block memory. The requester may be a processor port or another cache. It presents one word-sized read or write at a time over a valid/ready handshake. The controller keeps a tag, a valid bit, a dirty bit and an age counter for every line, and a small register array holds the line data. Hits are answered from these local arrays alone.

On a miss the controller allocates the requested block. It first makes room in the indexed set. An empty way is taken if one exists. Otherwise the oldest way becomes the victim, and if that victim is dirty it is written back. The controller then reads the requested block from below and installs it. After the fill it repeats the lookup, which now hits, and completes the access. A write miss therefore ends as a write hit on the freshly filled line.

The controller handles one request at a time and holds off the requester until that request is finished. Associativity, set count, block size, word width and address width are compile-time parameters. From them the address is split into a word offset, a set index and a tag.

Top module: `cache_wbwa`

## Requirements
- R1: A request that hits completes with no transaction on the memory port; the response (`rspValid`) appears in the cycle after the request is accepted.
- R2: A write that misses first fetches the block from memory, then applies the written word; later reads return the written word and other words of the block keep their memory values.
- R3: When the indexed set holds an invalid way, the fill uses it (the lowest-numbered one if several) and no write-back is issued.
- R4: When every way of the set is valid and the oldest way is dirty, that line is written to memory (`memWrite`=1) before the fill read (`memWrite`=0) of the requested block is issued, and the fill read follows in the cycle after the write completes.
- R5: A clean victim is replaced without any memory write; only a line that was written while resident is marked dirty, and a line filled from memory is clean.
- R6: Each way has a log2(ways)-bit age. Every access sets the age of the accessed way to 0 and increments the ages lower than the old age of that way. The way with the maximum age (ways-1) is the eviction victim.
- R7: `reqReady` is high only while the controller is idle; `rspValid` is a one-cycle pulse, after which the controller is idle again.
- R8: Every memory transaction addresses the set of the pending request. The block address (`memAddr`) is {tag, index}, and a fill read uses the pending request's own block address.
- R9: Once `memValid` is raised it stays high with `memAddr`, `memWrite` and `memWdata` stable until `memReady` is seen.
- R10: After reset, all lines are invalid, `reqReady` is 1, and `memValid` and `rspValid` are 0. The first access to any address then misses.
- R11: Sets are independent: misses and hits in one set do not disturb the lines or ages of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upper-level request present |
| reqReady | output | 1 | Controller idle, request accepted on this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address {tag, index, offset} |
| reqWdata | input | WORD_W | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | WORD_W | Read word (for a write, the word written) |
| memValid | output | 1 | Lower-level block request |
| memReady | input | 1 | Lower level completes the request on this edge |
| memWrite | output | 1 | 1 = write-back, 0 = fill read |
| memAddr | output | ADDR_W-OFF_W | Block address {tag, index} |
| memWdata | output | BLOCK_WORDS*WORD_W | Victim block for write-back, word 0 in low bits |
| memRdata | input | BLOCK_WORDS*WORD_W | Fill block, valid with memReady |

## Verification
The bound checker checks the port-level rules on every cycle. It covers the silence of the memory port during idle and response cycles, and the fill read that must follow every write-back at once. It also covers the set and block addresses of each memory transaction, the stability of a memory request until it completes, and the single-cycle response pulse. Victim choice and the age ordering can only be seen through the scenarios the bench runs. These include empty-way preference, oldest-way eviction, write-back of dirty versus clean victims, data returned after a write-back and refetch, set independence, and the empty cache after reset. The bench judges them by the data returned and by the count and order of memory reads and writes for each request.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_EVICT  = 2'd2,
    ST_FILL   = 2'd3
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch the incoming request
    logic latchVictim;  // remember the chosen way on a miss
    logic hitUpdate;    // ages update, write word, set dirty
    logic evictClear;   // write-back done, invalidate victim
    logic fillWrite;    // install fetched block
    logic selEvict;     // memory address/data from victim
  } ctlStrobes_t;
endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WORD_W      = 16,
  parameter int BLOCK_WORDS = 2,
  parameter int SETS        = 4,
  parameter int WAYS        = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobes_t                   stb,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [WORD_W-1:0]             reqWdata,
  input  logic [BLOCK_WORDS*WORD_W-1:0] memRdata,
  output logic                          hit,
  output logic                          victimNeedsWb,
  output logic [WORD_W-1:0]             rspData,
  output logic [ADDR_W-$clog2(BLOCK_WORDS)-1:0] memAddr,
  output logic [BLOCK_WORDS*WORD_W-1:0] memWdata
);
  localparam int OFF_W = $clog2(BLOCK_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int BLK_W = BLOCK_WORDS * WORD_W;
  localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(WAYS - 1);

  logic              pendWrite;
  logic [ADDR_W-1:0] pendAddr;
  logic [WORD_W-1:0] pendWdata;

  logic [TAG_W-1:0] tagArr   [SETS][WAYS];
  logic [BLK_W-1:0] dataArr  [SETS][WAYS];
  logic [WAY_W-1:0] ageArr   [SETS][WAYS];
  logic [WAYS-1:0]  validArr [SETS];
  logic [WAYS-1:0]  dirtyArr [SETS];

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign off = pendAddr[OFF_W-1:0];
  assign idx = pendAddr[OFF_W +: IDX_W];
  assign tag = pendAddr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay, freeWay, lruWay, vicWay;
  logic             freeFound;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[idx][w] && (tagArr[idx][w] == tag);
  end

  assign hit = |hitVec;

  always_comb begin
    hitWay    = '0;
    freeWay   = '0;
    freeFound = 1'b0;
    lruWay    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (ageArr[idx][w] == AGE_MAX) lruWay = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validArr[idx][w]) begin
        freeWay   = WAY_W'(w);
        freeFound = 1'b1;
      end
    end
  end

  assign victimNeedsWb = !freeFound && dirtyArr[idx][lruWay];

  logic [WORD_W-1:0] readWord;
  assign readWord = dataArr[idx][hitWay][off*WORD_W +: WORD_W];
  assign rspData  = pendWrite ? pendWdata : readWord;
  assign memAddr  = stb.selEvict ? {tagArr[idx][vicWay], idx} : {tag, idx};
  assign memWdata = dataArr[idx][vicWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWrite <= 1'b0;
      pendAddr  <= '0;
      pendWdata <= '0;
      vicWay    <= '0;
    end else begin
      if (stb.capture) begin
        pendWrite <= reqWrite;
        pendAddr  <= reqAddr;
        pendWdata <= reqWdata;
      end
      if (stb.latchVictim) vicWay <= freeFound ? freeWay : lruWay;
    end
  end

  // line state: valid, dirty, ages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageArr[s][w] <= WAY_W'(w);
      end
    end else begin
      if (stb.hitUpdate) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == hitWay)
            ageArr[idx][w] <= '0;
          else if (ageArr[idx][w] < ageArr[idx][hitWay])
            ageArr[idx][w] <= ageArr[idx][w] + 1'b1;
        end
        if (pendWrite) dirtyArr[idx][hitWay] <= 1'b1;
      end
      if (stb.evictClear) begin
        validArr[idx][vicWay] <= 1'b0;
        dirtyArr[idx][vicWay] <= 1'b0;
      end
      if (stb.fillWrite) begin
        validArr[idx][vicWay] <= 1'b1;
        dirtyArr[idx][vicWay] <= 1'b0;
      end
    end
  end

  // tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (stb.fillWrite) begin
      tagArr[idx][vicWay]  <= tag;
      dataArr[idx][vicWay] <= memRdata;
    end else if (stb.hitUpdate && pendWrite) begin
      dataArr[idx][hitWay][off*WORD_W +: WORD_W] <= pendWdata;
    end
  end
endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        victimNeedsWb,
  input  logic        memReady,
  output logic        reqReady,
  output logic        rspValid,
  output logic        memValid,
  output logic        memWrite,
  output ctlStrobes_t stb
);
  ctlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          nextState   = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          stb.hitUpdate = 1'b1;
          rspValid      = 1'b1;
          nextState     = ST_IDLE;
        end else begin
          stb.latchVictim = 1'b1;
          nextState       = victimNeedsWb ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        memValid     = 1'b1;
        memWrite     = 1'b1;
        stb.selEvict = 1'b1;
        if (memReady) begin
          stb.evictClear = 1'b1;
          nextState      = ST_FILL;
        end
      end
      ST_FILL: begin
        memValid = 1'b1;
        if (memReady) begin
          stb.fillWrite = 1'b1;
          nextState     = ST_LOOKUP;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/cache_wbwa.sv
module cache_wbwa
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WORD_W      = 16,
  parameter int BLOCK_WORDS = 2,
  parameter int SETS        = 4,
  parameter int WAYS        = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [WORD_W-1:0]             reqWdata,
  output logic                          rspValid,
  output logic [WORD_W-1:0]             rspData,
  output logic                          memValid,
  input  logic                          memReady,
  output logic                          memWrite,
  output logic [ADDR_W-$clog2(BLOCK_WORDS)-1:0] memAddr,
  output logic [BLOCK_WORDS*WORD_W-1:0] memWdata,
  input  logic [BLOCK_WORDS*WORD_W-1:0] memRdata
);
  ctlStrobes_t stb;
  logic        hit;
  logic        victimNeedsWb;

  cache_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .victimNeedsWb(victimNeedsWb), .memReady(memReady),
    .reqReady(reqReady), .rspValid(rspValid), .memValid(memValid),
    .memWrite(memWrite), .stb(stb)
  );

  cache_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS),
    .SETS(SETS), .WAYS(WAYS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memRdata(memRdata),
    .hit(hit), .victimNeedsWb(victimNeedsWb), .rspData(rspData),
    .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/cache_wbwa_checker.sv
module cache_wbwa_checker #(
  parameter int ADDR_W      = 12,
  parameter int WORD_W      = 16,
  parameter int BLOCK_WORDS = 2,
  parameter int SETS        = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          reqValid,
  input logic                          reqReady,
  input logic [ADDR_W-1:0]             reqAddr,
  input logic                          rspValid,
  input logic                          memValid,
  input logic                          memReady,
  input logic                          memWrite,
  input logic [ADDR_W-$clog2(BLOCK_WORDS)-1:0] memAddr,
  input logic [BLOCK_WORDS*WORD_W-1:0] memWdata
);
  localparam int OFF_W = $clog2(BLOCK_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int BA_W  = ADDR_W - OFF_W;

  logic [BA_W-1:0] pendBlock;
  always_ff @(posedge clk) begin
    if (!rstN)                    pendBlock <= '0;
    else if (reqValid && reqReady) pendBlock <= reqAddr[ADDR_W-1:OFF_W];
  end

  // R1: no memory traffic while idle or answering
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady || rspValid) |-> !memValid);

  // R4: fill read immediately follows a completed write-back
  assert_fill_after_evict_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && memWrite) |=> (memValid && !memWrite));

  // R7: response is a single pulse returning to idle
  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R8: every transaction stays in the pending set
  assert_same_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[IDX_W-1:0] == pendBlock[IDX_W-1:0]));

  // R8: fill read targets the pending block
  assert_fill_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite) |-> (memAddr == pendBlock));

  // R9: request held stable until accepted
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=>
      (memValid && $stable(memAddr) && $stable(memWrite) && $stable(memWdata)));
endmodule

bind cache_wbwa cache_wbwa_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS), .SETS(SETS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .rspValid(rspValid), .memValid(memValid),
  .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
  .memWdata(memWdata)
);

// File: tb/cache_wbwa_bench.sv
module cache_wbwa_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 16;
  localparam int BLOCK_WORDS = 2;
  localparam int BA_W = ADDR_W - 1;
  localparam int MEM_WORDS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [WORD_W-1:0] reqWdata = '0;
  logic reqReady, rspValid, memValid, memWrite;
  logic memReady;
  logic [WORD_W-1:0] rspData;
  logic [BA_W-1:0] memAddr;
  logic [BLOCK_WORDS*WORD_W-1:0] memWdata, memRdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_wbwa u_cache_wbwa (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memValid(memValid),
    .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // lower-level memory model: ready two cycles after request
  logic [WORD_W-1:0] memW [MEM_WORDS];
  logic [1:0] waitCnt;
  int rdCount = 0, wrCount = 0, txnCount = 0;
  logic txnLog [256];

  assign memRdata = {memW[{memAddr, 1'b1}], memW[{memAddr, 1'b0}]};

  initial begin
    for (int a = 0; a < MEM_WORDS; a++) memW[a] = WORD_W'(a) ^ 16'hA500;
  end

  always @(posedge clk) begin
    if (!memValid) begin
      memReady <= 1'b0;
      waitCnt  <= 2'd0;
    end else if (memReady) begin
      memReady <= 1'b0;
      waitCnt  <= 2'd0;
      if (memWrite) begin
        memW[{memAddr, 1'b0}] <= memWdata[WORD_W-1:0];
        memW[{memAddr, 1'b1}] <= memWdata[2*WORD_W-1:WORD_W];
        wrCount <= wrCount + 1;
      end else begin
        rdCount <= rdCount + 1;
      end
      txnLog[txnCount[7:0]] <= memWrite;
      txnCount <= txnCount + 1;
    end else begin
      waitCnt  <= waitCnt + 1'b1;
      memReady <= (waitCnt == 2'd1);
    end
  end

  int checks = 0, fails = 0;
  logic doneFlag = 1'b0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [WORD_W-1:0] d, output logic [WORD_W-1:0] q);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0 || rspValid, "R7 reqReady while busy", reqReady, 0);
    while (!rspValid) @(negedge clk);
    q = rspData;
  endtask

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
    logic              chk;
    logic [WORD_W-1:0] expData;
    logic [1:0]        expRd;
    logic [1:0]        expWr;
  } vec_t;

  // set 0: addr = tag*8 + offset; memory word a holds a ^ A500
  localparam vec_t VECS [18] = '{
    '{1'b0, 12'd8,  16'h0,    1'b1, 16'hA508, 2'd1, 2'd0}, // R3 empty way0
    '{1'b1, 12'd9,  16'h1111, 1'b0, 16'h0,    2'd0, 2'd0}, // R1 write hit
    '{1'b0, 12'd9,  16'h0,    1'b1, 16'h1111, 2'd0, 2'd0}, // R1 read hit
    '{1'b0, 12'd16, 16'h0,    1'b1, 16'hA510, 2'd1, 2'd0}, // R3 way1
    '{1'b0, 12'd24, 16'h0,    1'b1, 16'hA518, 2'd1, 2'd0}, // R3 way2
    '{1'b0, 12'd32, 16'h0,    1'b1, 16'hA520, 2'd1, 2'd0}, // R3 way3
    '{1'b1, 12'd40, 16'h2222, 1'b0, 16'h0,    2'd1, 2'd1}, // R2 R4 dirty oldest
    '{1'b0, 12'd9,  16'h0,    1'b1, 16'h1111, 2'd1, 2'd0}, // R4 written back, R5 clean victim
    '{1'b0, 12'd16, 16'h0,    1'b1, 16'hA510, 2'd1, 2'd0}, // R6 next oldest
    '{1'b0, 12'd40, 16'h0,    1'b1, 16'h2222, 2'd0, 2'd0}, // R1 R6 hit refresh
    '{1'b0, 12'd48, 16'h0,    1'b1, 16'hA530, 2'd1, 2'd0}, // R6 victim tag4
    '{1'b0, 12'd56, 16'h0,    1'b1, 16'hA538, 2'd1, 2'd0}, // R5 refilled line clean
    '{1'b0, 12'd64, 16'h0,    1'b1, 16'hA540, 2'd1, 2'd0}, // R6
    '{1'b0, 12'd72, 16'h0,    1'b1, 16'hA548, 2'd1, 2'd1}, // R4 dirty tag5 evicted
    '{1'b0, 12'd41, 16'h0,    1'b1, 16'hA529, 2'd1, 2'd0}, // R2 untouched word kept
    '{1'b0, 12'd2,  16'h0,    1'b1, 16'hA502, 2'd1, 2'd0}, // R11 other set empty
    '{1'b1, 12'd3,  16'h3333, 1'b0, 16'h0,    2'd0, 2'd0}, // R11 hit in set1
    '{1'b0, 12'd72, 16'h0,    1'b1, 16'hA548, 2'd0, 2'd0}  // R11 set0 unaffected
  };

  initial begin
    logic [WORD_W-1:0] q;
    int r0, w0, t0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R10 reqReady after reset", reqReady, 1);
    check(memValid == 1'b0, "R10 memValid after reset", memValid, 0);
    check(rspValid == 1'b0, "R10 rspValid after reset", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && !memValid, "R10 idle after release", reqReady, 1);

    for (int i = 0; i < 18; i++) begin
      r0 = rdCount; w0 = wrCount; t0 = txnCount;
      doReq(VECS[i].wr, VECS[i].addr, VECS[i].wdata, q);
      if (VECS[i].chk)
        check(q == VECS[i].expData, $sformatf("R1/R6 vec %0d data", i), q, VECS[i].expData);
      check(rdCount - r0 == int'(VECS[i].expRd), $sformatf("R3/R6 vec %0d reads", i),
            rdCount - r0, VECS[i].expRd);
      check(wrCount - w0 == int'(VECS[i].expWr), $sformatf("R5 vec %0d writes", i),
            wrCount - w0, VECS[i].expWr);
      if (VECS[i].expWr != 0)
        check(txnLog[t0[7:0]] == 1'b1, $sformatf("R4 vec %0d write-back first", i),
              txnLog[t0[7:0]], 1);
    end

    // R11: set1 word written at vec 16 still read back
    doReq(1'b0, 12'd3, 16'h0, q);
    check(q == 16'h3333, "R11 set1 data", q, 16'h3333);

    // R7: response lasts exactly one cycle
    @(negedge clk);
    check(rspValid == 1'b0 && reqReady == 1'b1, "R7 single pulse", rspValid, 0);

    // R10: mid-run reset empties the cache
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(reqReady && !memValid && !rspValid, "R10 outputs in reset", reqReady, 1);
    rstN = 1'b1;
    r0 = rdCount; w0 = wrCount;
    doReq(1'b0, 12'd72, 16'h0, q);
    check(rdCount - r0 == 1, "R10 miss after reset", rdCount - r0, 1);
    check(wrCount - w0 == 0, "R10 no write-back of lost dirty", wrCount - w0, 0);
    check(q == 16'hA548, "R10 refetched data", q, 16'hA548);

    // R2: write miss to an empty set, then read both words
    r0 = rdCount;
    doReq(1'b1, 12'd5, 16'h5555, q);
    check(rdCount - r0 == 1, "R2 write miss fetches", rdCount - r0, 1);
    doReq(1'b0, 12'd5, 16'h0, q);
    check(q == 16'h5555, "R2 written word", q, 16'h5555);
    doReq(1'b0, 12'd4, 16'h0, q);
    check(q == 16'hA504, "R2 neighbour word", q, 16'hA504);

    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule